// File: doc/BRIEF.md
# Register-Memory Processor Core

This block is a small multi-cycle processor whose arithmetic instructions combine one operand read from a 32-entry register file with a second operand read directly from data memory, and place the result in a named register. Every instruction names its destination register, its source register and its memory address explicitly; no operand is implied by the machine.

Instructions come from a fetch port that returns a word combinationally for the address the core presents. Data memory is byte-wide and synchronous: a read returns its byte on the clock edge after the address is presented, and a write takes effect on the edge where the write strobe is high. A debug port lets the surrounding logic read any register at any time. The core stops on a halt instruction and raises a halt flag that stays high until reset.

Top module: `rmc_core`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the instruction address is 0, the halt flag is low and every register reads 0 through the debug port.
- R2: An instruction word is 22 bits: opcode in bits 21:18, destination register in 17:13, source register in 12:8, memory address in 7:0. Opcodes: 1 load, 2 store, 3 add, 4 subtract, 5 multiply, 15 halt; all other values do nothing.
- R3: Load writes the memory byte at the address into the destination register; the source field has no effect.
- R4: Store writes the register named in the destination field to the memory address and changes no register.
- R5: Add, subtract and multiply write source register plus, minus or times the memory byte into the destination register, keeping the low 8 bits; the source register is read before the destination is written, so destination and source may be the same register.
- R6: Arithmetic and load results go only to a register; data memory is written only by store.
- R7: Load and the three arithmetic instructions take 3 clock cycles, store and unused opcodes take 2, and the instruction address advances by one after each.
- R8: Halt takes 2 cycles, after which the halt flag stays high, the instruction address stays fixed and no register or memory location changes.
- R9: The debug port returns the selected register in the same cycle; during a cycle in which that register is being written it returns the old value.
- R10: The sequence load R1,a; add R2,R1,b; multiply R3,R2,c; store R3,d leaves (a+b)*c at d, with R1=a, R2=a+b and R3=(a+b)*c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Instruction address (program counter) |
| imem_data | input | 22 | Instruction word at imem_addr |
| dmem_addr | output | 8 | Data memory byte address |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_wdata | output | 8 | Data memory write byte |
| dmem_rdata | input | 8 | Byte read from the address of the previous cycle |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_data | output | 8 | Contents of the selected register |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
A wrong sequencer state shows up as a changed cycle count to halt, which the bench measures for every program, or as a write strobe in a cycle where none belongs, which a property catches on the cycle it happens. A wrong register value stays hidden until a store or the debug port exposes it, so after each program the bench sweeps all 32 registers and all 256 memory bytes against a reference interpreter. The old-value rule on the debug port is sampled in the write-back cycle itself and once more one cycle later.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

    localparam int DATA_W  = 8;
    localparam int MADDR_W = 8;
    localparam int REG_N   = 32;
    localparam int REG_W   = $clog2(REG_N);
    localparam int OPC_W   = 4;
    localparam int INSTR_W = OPC_W + 2 * REG_W + MADDR_W;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_ADD   = 4'd3,
        OP_SUB   = 4'd4,
        OP_MUL   = 4'd5,
        OP_HALT  = 4'd15
    } opcode_e;

    typedef struct packed {
        opcode_e              op;
        logic [REG_W-1:0]     rd;
        logic [REG_W-1:0]     rs;
        logic [MADDR_W-1:0]   addr;
    } instr_t;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_ISSUE,
        ST_WBACK,
        ST_HALT
    } state_e;

    // Instructions that need the memory byte and a register write-back
    function automatic logic needs_wback(opcode_e op);
        return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
    endfunction

    function automatic logic [DATA_W-1:0] compute(opcode_e op,
                                                  logic [DATA_W-1:0] reg_val,
                                                  logic [DATA_W-1:0] mem_val);
        logic [2*DATA_W-1:0] prod;
        prod = reg_val * mem_val;
        unique case (op)
            OP_ADD:  return reg_val + mem_val;
            OP_SUB:  return reg_val - mem_val;
            OP_MUL:  return prod[DATA_W-1:0];
            default: return mem_val;
        endcase
    endfunction

endpackage

// File: rtl/rmc_regfile.sv
module rmc_regfile
    import rmc_pkg::*;
#(
    parameter int NREGS = REG_N,
    parameter int WIDTH = DATA_W,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata,
    input  logic [IW-1:0]    dbg_addr,
    output logic [WIDTH-1:0] dbg_rdata,
    input  logic             we,
    input  logic [IW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata
);

    logic [WIDTH-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    // Reads see the stored value; a write lands only at the next edge
    assign rdata     = regs[raddr];
    assign dbg_rdata = regs[dbg_addr];

endmodule

// File: rtl/rmc_ctrl.sv
module rmc_ctrl
    import rmc_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [PC_W-1:0]    pc,
    output opcode_e            cur_op,
    output logic [REG_W-1:0]   rf_raddr,
    output logic [REG_W-1:0]   rf_waddr,
    output logic               rf_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic               mem_we,
    output logic               halted
);

    state_e state;
    instr_t ir;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
            pc    <= '0;
            ir    <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir    <= instr_t'(imem_data);
                    state <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (ir.op == OP_HALT) begin
                        state <= ST_HALT;
                    end else if (needs_wback(ir.op)) begin
                        state <= ST_WBACK;
                    end else begin
                        pc    <= pc + 1'b1;
                        state <= ST_FETCH;
                    end
                end
                ST_WBACK: begin
                    pc    <= pc + 1'b1;
                    state <= ST_FETCH;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    assign cur_op   = ir.op;
    assign mem_addr = ir.addr;
    assign mem_we   = (state == ST_ISSUE) && (ir.op == OP_STORE);
    // Store reads the register named in the destination field
    assign rf_raddr = (state == ST_ISSUE) ? ir.rd : ir.rs;
    assign rf_waddr = ir.rd;
    assign rf_we    = (state == ST_WBACK);
    assign halted   = (state == ST_HALT);

endmodule

// File: rtl/rmc_exec.sv
module rmc_exec
    import rmc_pkg::*;
(
    input  opcode_e           op,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] mem_val,
    output logic [DATA_W-1:0] result
);

    always_comb begin
        result = compute(op, reg_val, mem_val);
    end

endmodule

// File: rtl/rmc_core.sv
module rmc_core
    import rmc_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [MADDR_W-1:0] dmem_addr,
    output logic               dmem_we,
    output logic [DATA_W-1:0]  dmem_wdata,
    input  logic [DATA_W-1:0]  dmem_rdata,
    input  logic [REG_W-1:0]   dbg_sel,
    output logic [DATA_W-1:0]  dbg_data,
    output logic               halted
);

    opcode_e             cur_op;
    logic [REG_W-1:0]    rf_raddr;
    logic [REG_W-1:0]    rf_waddr;
    logic                rf_we;
    logic [DATA_W-1:0]   rf_rdata;
    logic [DATA_W-1:0]   wb_data;

    rmc_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .imem_data (imem_data),
        .pc        (imem_addr),
        .cur_op    (cur_op),
        .rf_raddr  (rf_raddr),
        .rf_waddr  (rf_waddr),
        .rf_we     (rf_we),
        .mem_addr  (dmem_addr),
        .mem_we    (dmem_we),
        .halted    (halted)
    );

    rmc_regfile #(.NREGS(REG_N), .WIDTH(DATA_W)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .raddr     (rf_raddr),
        .rdata     (rf_rdata),
        .dbg_addr  (dbg_sel),
        .dbg_rdata (dbg_data),
        .we        (rf_we),
        .waddr     (rf_waddr),
        .wdata     (wb_data)
    );

    rmc_exec u_exec (
        .op      (cur_op),
        .reg_val (rf_rdata),
        .mem_val (dmem_rdata),
        .result  (wb_data)
    );

    assign dmem_wdata = rf_rdata;

endmodule

// File: rtl/rmc_core_chk.sv
module rmc_core_chk #(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] imem_addr,
    input logic            dmem_we,
    input logic            rf_we,
    input logic            halted,
    input logic [4:0]      dbg_sel,
    input logic [7:0]      dbg_data
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && !halted));

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!dmem_we && !rf_we));

    // R8
    halt_pc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(imem_addr));

    // R6
    store_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(dmem_we && rf_we));

    // R7
    store_advance_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> (imem_addr == PC_W'($past(imem_addr) + 1'b1)));

    // R7
    wback_single_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);

    // R9
    dbg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rf_we |=> (!$stable(dbg_sel) || $stable(dbg_data)));

endmodule

bind rmc_core rmc_core_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .rf_we     (rf_we),
    .halted    (halted),
    .dbg_sel   (dbg_sel),
    .dbg_data  (dbg_data)
);

// File: tb/rmc_core_tb.sv
`timescale 1ns/1ps
module rmc_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [21:0] imem_data;
    logic [7:0]  dmem_addr;
    logic        dmem_we;
    logic [7:0]  dmem_wdata;
    logic [7:0]  dmem_rdata;
    logic [4:0]  dbg_sel = '0;
    logic [7:0]  dbg_data;
    logic        halted;

    always #2.5 clk = ~clk;

    logic [21:0] prog [256];
    logic [7:0]  dmem [256];
    logic [7:0]  ref_mem [256];
    logic [7:0]  ref_regs [32];
    int          exp_cycles;
    int          n_checks = 0;
    int          n_fails  = 0;

    rmc_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dbg_sel    (dbg_sel),
        .dbg_data   (dbg_data),
        .halted     (halted)
    );

    assign imem_data = prog[imem_addr];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
        dmem_rdata <= dmem[dmem_addr];
    end

    function automatic logic [21:0] enc(int op, int rd, int rs, int addr);
        return {op[3:0], rd[4:0], rs[4:0], addr[7:0]};
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Reference interpreter built from the requirements
    task automatic ref_exec();
        int pc = 0;
        exp_cycles = 0;
        for (int i = 0; i < 32; i++) ref_regs[i] = '0;
        for (int i = 0; i < 256; i++) ref_mem[i] = dmem[i];
        for (int step = 0; step < 256; step++) begin
            logic [21:0] w  = prog[pc];
            int          op = int'(w[21:18]);
            int          rd = int'(w[17:13]);
            int          rs = int'(w[12:8]);
            int          ad = int'(w[7:0]);
            logic [15:0] p;
            if (op == 15) begin exp_cycles += 2; break; end
            case (op)
                1: begin ref_regs[rd] = ref_mem[ad]; exp_cycles += 3; end
                2: begin ref_mem[ad] = ref_regs[rd]; exp_cycles += 2; end
                3: begin ref_regs[rd] = ref_regs[rs] + ref_mem[ad]; exp_cycles += 3; end
                4: begin ref_regs[rd] = ref_regs[rs] - ref_mem[ad]; exp_cycles += 3; end
                5: begin p = ref_regs[rs] * ref_mem[ad]; ref_regs[rd] = p[7:0]; exp_cycles += 3; end
                default: exp_cycles += 2;
            endcase
            pc = (pc + 1) % 256;
        end
    endtask

    task automatic do_reset_check();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(imem_addr == 8'd0, "R1 pc", int'(imem_addr), 0);
        chk(!halted, "R1 halt", int'(halted), 0);
        for (int r = 0; r < 32; r++) begin
            dbg_sel = r[4:0];
            #0.5;
            chk(dbg_data == 8'd0, "R1 reg", int'(dbg_data), 0);
        end
        rst = 1'b0;
    endtask

    task automatic run_and_check(string name);
        int n = 0;
        logic [7:0] pc_hold;
        ref_exec();
        do_reset_check();
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (halted || n > 3000) break;
        end
        chk(n == exp_cycles, {"R7 cycles ", name}, n, exp_cycles);
        pc_hold = imem_addr;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(halted && imem_addr == pc_hold, {"R8 hold ", name}, int'(imem_addr), int'(pc_hold));
        for (int r = 0; r < 32; r++) begin
            dbg_sel = r[4:0];
            #0.5;
            chk(dbg_data == ref_regs[r], {"R3 R5 reg ", name}, int'(dbg_data), int'(ref_regs[r]));
        end
        for (int a = 0; a < 256; a++)
            chk(dmem[a] == ref_mem[a], {"R4 R6 mem ", name}, int'(dmem[a]), int'(ref_mem[a]));
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = enc(15, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd51207));
        for (int i = 0; i < 256; i++) dmem[i] = 8'($urandom);

        // R10: the worked sequence
        clear_prog();
        dmem[8'h10] = 8'd6; dmem[8'h12] = 8'd7; dmem[8'h13] = 8'd5; dmem[8'h20] = 8'd0;
        prog[0] = enc(1, 1, 0, 8'h10);
        prog[1] = enc(3, 2, 1, 8'h12);
        prog[2] = enc(5, 3, 2, 8'h13);
        prog[3] = enc(2, 3, 0, 8'h20);
        run_and_check("seq");
        chk(dmem[8'h20] == 8'd65, "R10 d", int'(dmem[8'h20]), 65);
        dbg_sel = 5'd1; #0.5; chk(dbg_data == 8'd6,  "R10 R1", int'(dbg_data), 6);
        dbg_sel = 5'd2; #0.5; chk(dbg_data == 8'd13, "R10 R2", int'(dbg_data), 13);
        dbg_sel = 5'd3; #0.5; chk(dbg_data == 8'd65, "R10 R3", int'(dbg_data), 65);

        // R2 R3 R4 R5: corner cases (wrap, same register, ignored fields, unused opcode)
        clear_prog();
        dmem[8'h30] = 8'd200; dmem[8'h31] = 8'd3; dmem[8'h32] = 8'd5; dmem[8'hFF] = 8'd9;
        prog[0] = enc(1, 5, 31, 8'h30);   // load, source field ignored
        prog[1] = enc(5, 6, 5, 8'h31);    // 200*3 -> 88
        prog[2] = enc(1, 7, 0, 8'h31);    // 3
        prog[3] = enc(4, 8, 7, 8'h32);    // 3-5 -> 254
        prog[4] = enc(3, 5, 5, 8'hFF);    // R5 = 200+9 = 209
        prog[5] = enc(7, 9, 9, 8'h00);    // unused opcode: nothing
        prog[6] = enc(2, 8, 5, 8'hFF);    // mem[FF] = R8
        run_and_check("corner");
        dbg_sel = 5'd6; #0.5; chk(dbg_data == 8'd88,  "R5 mul wrap", int'(dbg_data), 88);
        dbg_sel = 5'd8; #0.5; chk(dbg_data == 8'd254, "R5 sub wrap", int'(dbg_data), 254);
        dbg_sel = 5'd5; #0.5; chk(dbg_data == 8'd209, "R5 same reg", int'(dbg_data), 209);
        chk(dmem[8'hFF] == 8'd254, "R4 store rd", int'(dmem[8'hFF]), 254);

        // R9: old value during the write-back cycle
        clear_prog();
        dmem[8'h05] = 8'h5A;
        prog[0] = enc(1, 7, 0, 8'h05);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        dbg_sel = 5'd7;
        @(posedge clk);          // into issue
        @(posedge clk);          // into write-back
        @(negedge clk);
        chk(dbg_data == 8'd0, "R9 old value", int'(dbg_data), 0);
        @(posedge clk);
        @(negedge clk);
        chk(dbg_data == 8'h5A, "R9 new value", int'(dbg_data), 8'h5A);

        // Random programs
        for (int t = 0; t < 6; t++) begin
            int len = 20 + int'($urandom_range(0, 20));
            clear_prog();
            for (int i = 0; i < 256; i++) dmem[i] = 8'($urandom);
            for (int i = 0; i < len; i++) begin
                int op = int'($urandom_range(1, 5));
                if ($urandom_range(0, 9) == 0) op = int'($urandom_range(6, 14));
                prog[i] = enc(op, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                              int'($urandom_range(0, 255)));
            end
            run_and_check($sformatf("rand%0d", t));
        end

        // R1: reset clears registers that hold data
        do_reset_check();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule